// File: doc/BRIEF.md
# Byte-Wide Serial Port with Register Interface

This block is a small asynchronous serial port behind an eight-offset, byte-wide register bus. Software programs a 16-bit rate divisor, writes bytes to send, and reads received bytes. Status flags and an interrupt output report arrivals and overruns. Framing is fixed at eight data bits, no parity and one stop bit, with the least significant bit sent first.

Bit 7 of the line control register is the divisor-access bit. While it is set, offsets 0 and 1 reach the low and high divisor bytes instead of the data and interrupt-enable registers. A free-running tick generator produces the 16x sampling rate. The receiver confirms a start bit at its middle sample and places each byte in a receive buffer. The buffer holds one byte when queueing is off and `RX_DEPTH` bytes when it is on. Reads of the line status register clear the sticky overrun flag.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, offset 3 reads 0x03, offset 5 reads 0x60, offset 2 reads 0x01, offset 1 reads 0x00, `tx` is high, `irq` is low and the divisor is 1.
- R2: While offset 3 bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes. While that bit is 0, they reach the data and interrupt-enable registers, and the divisor keeps its value.
- R3: A byte written to offset 0 leaves `tx` as a low start bit, eight data bits LSB first and a high stop bit. Each bit lasts 16 x divisor x `CLKS_PER_TICK` clocks, so a divisor of 12 gives one twelfth of the divisor-1 rate, for example 9600 from 115200.
- R4: The receiver samples `rx` at 16 ticks per bit and confirms the start bit at the eighth tick. A low pulse shorter than half a bit stores nothing.
- R5: Offset 5 bit 0 shows that received data is waiting, bit 1 shows an overrun, bit 5 shows that the transmit holding register is empty, and bit 6 shows that both the holding register and the shifter are empty. Bit 5 drops in the cycle after a write to offset 0.
- R6: Offset 1 bit 0 enables the received-data interrupt. `irq` is high and offset 2 reads 0x04 exactly while that bit is set and data is waiting. Otherwise `irq` is low and offset 2 reads 0x01.
- R7: With queueing off (offset 2 written with bit 0 = 0), the receiver holds one byte. A further byte that completes while one is held is dropped and sets the overrun flag.
- R8: With queueing on (bit 0 = 1), up to `RX_DEPTH` bytes are held and returned in arrival order. One more sets the overrun flag and is dropped.
- R9: A read of offset 5 returns the overrun flag and then clears it, unless a new overrun arises in that same cycle.
- R10: A byte that completes in the same cycle as a read of offset 0 is stored without overrun, even when the buffer was full.
- R11: Any write to offset 2 empties the receive buffer.
- R12: Offsets 4, 6 and 7 read 0x00, and writes to them change nothing visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; carries the read side effects |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Received-data interrupt |
| rx | input | 1 | Serial input, idle high |
| tx | output | 1 | Serial output, idle high |

## Verification
A receive completion and a software read of the data register can land on the same clock edge, and only then does the full check have to count the freed slot. The bench first finds the exact edge at which a byte is stored, by watching the ready flag without a read strobe. It then repeats the same frame with one byte already held and issues the data read on that edge and on the edge after. On the coincident edge it expects no overrun and the second byte waiting. One edge later it expects the overrun flag and an empty buffer.

// File: rtl/serial_port_regs.sv
`timescale 1ns/1ps
module serial_port_regs #(
  parameter int CLKS_PER_TICK = 1,
  parameter int RX_DEPTH      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       rx,
  output logic       tx
);
  localparam int PW  = $clog2(RX_DEPTH);
  localparam int PRW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

  logic [7:0] lcr, dll, dlm;
  logic [3:0] ier;
  logic       fifo_en;
  wire        dlab = lcr[7];

  wire wr_thr = wr_en && addr == 3'd0 && !dlab;
  wire wr_fcr = wr_en && addr == 3'd2;
  wire rd_rbr = rd_en && addr == 3'd0 && !dlab;
  wire rd_lsr = rd_en && addr == 3'd5;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcr <= 8'h03; dll <= 8'h01; dlm <= 8'h00; ier <= 4'h0; fifo_en <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        3'd0: if (dlab) dll <= wdata;
        3'd1: if (dlab) dlm <= wdata; else ier <= wdata[3:0];
        3'd2: fifo_en <= wdata[0];
        3'd3: lcr <= wdata;
        default: ;
      endcase
    end

  // tick generator: one 16x sample tick per divisor count
  logic [PRW-1:0] pre;
  logic [15:0]    dcnt;
  wire  [15:0]    div_val  = {dlm, dll};
  wire  [15:0]    div_m1   = (div_val == 16'd0) ? 16'd0 : div_val - 16'd1;
  wire            pre_done = (pre == PRW'(CLKS_PER_TICK - 1));
  wire            tick     = pre_done && (dcnt >= div_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0; dcnt <= '0;
    end else if (pre_done) begin
      pre  <= '0;
      dcnt <= (dcnt >= div_m1) ? 16'd0 : dcnt + 16'd1;
    end else
      pre <= pre + PRW'(1);

  // receiver
  logic       rx_s1, rx_s2, rx_busy;
  logic [3:0] rx_ph, rx_idx;
  logic [7:0] rx_sh;
  wire push = tick && rx_busy && rx_ph == 4'd7 && rx_idx == 4'd9 && rx_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1; rx_busy <= 1'b0;
      rx_ph <= '0; rx_idx <= '0; rx_sh <= '0;
    end else begin
      rx_s1 <= rx; rx_s2 <= rx_s1;
      if (tick) begin
        if (!rx_busy) begin
          if (!rx_s2) begin rx_busy <= 1'b1; rx_ph <= '0; rx_idx <= '0; end
        end else begin
          rx_ph <= rx_ph + 4'd1;
          if (rx_ph == 4'd7) begin
            rx_idx <= rx_idx + 4'd1;
            if ((rx_idx == 4'd0 && rx_s2) || rx_idx == 4'd9) rx_busy <= 1'b0;
            else if (rx_idx != 4'd0) rx_sh <= {rx_s2, rx_sh[7:1]};
          end
        end
      end
    end

  // receive buffer
  logic [7:0]    mem [RX_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          oe;
  wire [PW:0] cap     = fifo_en ? (PW+1)'(RX_DEPTH) : (PW+1)'(1);
  wire        dr      = cnt != '0;
  wire        pop     = rd_rbr && dr;
  wire        full    = cnt >= cap;
  wire        do_push = push && (!full || pop);
  wire        ovf     = push && full && !pop;

  always_ff @(posedge clk)
    if (do_push && !wr_fcr) mem[wp] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; oe <= 1'b0;
    end else begin
      if (wr_fcr) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (do_push) wp <= wp + PW'(1);
        if (pop)     rp <= rp + PW'(1);
        cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(pop);
      end
      if (ovf) oe <= 1'b1;
      else if (rd_lsr) oe <= 1'b0;
    end

  // transmitter
  logic [7:0] hold;
  logic       hold_full, tx_busy;
  logic [9:0] tx_sh;
  logic [3:0] tx_ph, tx_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0; tx_busy <= 1'b0;
      tx_sh <= '1; tx_ph <= '0; tx_idx <= '0;
    end else begin
      if (wr_thr) begin hold <= wdata; hold_full <= 1'b1; end
      else if (!tx_busy && hold_full) hold_full <= 1'b0;
      if (!tx_busy) begin
        if (hold_full) begin
          tx_sh <= {1'b1, hold, 1'b0}; tx_busy <= 1'b1; tx_ph <= '0; tx_idx <= '0;
        end
      end else if (tick) begin
        tx_ph <= tx_ph + 4'd1;
        if (tx_ph == 4'd15) begin
          tx_sh  <= {1'b1, tx_sh[9:1]};
          tx_idx <= tx_idx + 4'd1;
          if (tx_idx == 4'd9) tx_busy <= 1'b0;
        end
      end
    end

  assign tx = tx_busy ? tx_sh[0] : 1'b1;

  wire       thre    = !hold_full;
  wire       temt    = !hold_full && !tx_busy;
  wire       pending = ier[0] && dr;
  wire [7:0] lsr     = {1'b0, temt, thre, 3'b000, oe, dr};
  assign irq = pending;

  always_comb
    case (addr)
      3'd0:    rdata = dlab ? dll : mem[rp];
      3'd1:    rdata = dlab ? dlm : {4'h0, ier};
      3'd2:    rdata = pending ? 8'h04 : 8'h01;
      3'd3:    rdata = lcr;
      3'd5:    rdata = lsr;
      default: rdata = 8'h00;
    endcase

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) !fifo_en |-> cnt <= (PW+1)'(1)); // R7
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) oe && !rd_lsr |=> oe); // R9
  AST_OE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rd_lsr && !ovf |=> !oe); // R9
  AST_THR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) wr_thr |=> !thre); // R5
  AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n) tx_busy && tx_idx == 4'd0 |-> !tx); // R3
  AST_DR_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(dr) |-> $past(pop || wr_fcr)); // R11
  AST_SWAP_SLOT: assert property (@(posedge clk) disable iff (!rst_n) push && pop && !wr_fcr |=> cnt == $past(cnt)); // R10
endmodule

// File: tb/serial_port_regs_bench.sv
`timescale 1ns/1ps
module serial_port_regs_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rx = 1'b1;
  logic [7:0] rdata;
  logic       irq, tx;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_port_regs u_serial_port_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .irq(irq), .rx(rx), .tx(tx));

  // {req[3:0], wr, addr[2:0], data[7:0], expected[7:0]}
  localparam int NV = 23;
  localparam logic [23:0] VEC [NV] = '{
    24'h130003, 24'h150060, 24'h120001, 24'h110000,      // R1
    24'h2B8300, 24'h283400, 24'h291200, 24'h200034,      // R2
    24'h210012, 24'h230083, 24'h280100, 24'h290000,      // R2
    24'h2B0300, 24'h210000,                              // R2
    24'hCF5A00, 24'hC70000, 24'hCCFF00, 24'hC40000,      // R12
    24'hCEFF00, 24'hC60000,                              // R12
    24'h690100, 24'h610001, 24'h620001 };                // R6

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic set_div(input logic [15:0] dv);
    bus_write(3'd3, 8'h83); bus_write(3'd0, dv[7:0]); bus_write(3'd1, dv[15:8]);
    bus_write(3'd3, 8'h03);
  endtask

  task automatic send_rx(input logic [7:0] b, input int bc, input bit full);
    @(negedge clk); rx = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (bc) @(negedge clk);
    end
    rx = 1'b1;
    if (full) repeat (bc + 4) @(negedge clk);
  endtask

  task automatic tx_expect(input logic [7:0] b, input int bc, input string tag);
    logic [9:0] fr;
    int n;
    fr = {1'b1, b, 1'b0};
    n = 0;
    while (tx === 1'b1 && n < 200) begin @(negedge clk); n++; end
    repeat (bc / 2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      chk(tag, {7'd0, tx}, {7'd0, fr[i]});
      repeat (bc) @(negedge clk);
    end
  endtask

  logic [7:0] d;
  int k;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx idle", {7'd0, tx}, 8'h01);
    chk("R1 irq low", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) bus_write(VEC[i][18:16], VEC[i][15:8]);
      else begin
        bus_read(VEC[i][18:16], d);
        tests++;
        if (d !== VEC[i][7:0]) begin
          fails++;
          $display("FAIL R%0d table entry %0d: got 0x%02h expected 0x%02h",
                   VEC[i][23:20], i, d, VEC[i][7:0]);
        end
      end
    end

    // R6: interrupt enabled, queueing off
    bus_write(3'd2, 8'h00);
    send_rx(8'h5A, 16, 1'b1);
    repeat (4) @(negedge clk);
    peek(3'd5, d); chk("R4 data ready", d & 8'h01, 8'h01);
    chk("R6 irq with data", {7'd0, irq}, 8'h01);
    peek(3'd2, d); chk("R6 ident pending", d, 8'h04);
    bus_read(3'd0, d); chk("R4 received byte", d, 8'h5A);
    chk("R6 irq cleared", {7'd0, irq}, 8'h00);
    peek(3'd2, d); chk("R6 ident idle", d, 8'h01);

    // R4: short glitch ignored
    @(negedge clk); rx = 1'b0;
    repeat (5) @(negedge clk); rx = 1'b1;
    repeat (300) @(negedge clk);
    peek(3'd5, d); chk("R4 glitch ignored", d & 8'h01, 8'h00);

    // R6: enable off masks irq
    bus_write(3'd1, 8'h00);
    send_rx(8'hC3, 16, 1'b1);
    repeat (4) @(negedge clk);
    chk("R6 irq masked", {7'd0, irq}, 8'h00);
    peek(3'd2, d); chk("R6 ident masked", d, 8'h01);
    bus_read(3'd0, d); chk("R4 second byte", d, 8'hC3);

    // R7 / R9: single slot overrun and read-to-clear
    send_rx(8'h11, 16, 1'b1);
    send_rx(8'h22, 16, 1'b1);
    repeat (4) @(negedge clk);
    peek(3'd5, d); chk("R7 overrun flagged", d & 8'h03, 8'h03);
    bus_read(3'd5, d); chk("R9 read shows overrun", d & 8'h02, 8'h02);
    peek(3'd5, d); chk("R9 overrun cleared", d & 8'h02, 8'h00);
    bus_read(3'd0, d); chk("R7 first byte kept", d, 8'h11);
    peek(3'd5, d); chk("R7 second dropped", d & 8'h01, 8'h00);

    // R8: queueing on, depth 4
    bus_write(3'd2, 8'h01);
    for (int i = 1; i <= 5; i++) send_rx(8'(i), 16, 1'b1);
    repeat (4) @(negedge clk);
    peek(3'd5, d); chk("R8 overrun on fifth", d & 8'h03, 8'h03);
    for (int i = 1; i <= 4; i++) begin
      bus_read(3'd0, d); chk("R8 order", d, 8'(i));
    end
    peek(3'd5, d); chk("R8 fifth dropped", d & 8'h01, 8'h00);
    bus_read(3'd5, d);

    // R11: control write flushes
    send_rx(8'hAA, 16, 1'b1);
    send_rx(8'hBB, 16, 1'b1);
    bus_write(3'd2, 8'h01);
    peek(3'd5, d); chk("R11 flushed", d & 8'h01, 8'h00);

    // R10: completion coincides with data read
    bus_write(3'd2, 8'h00);
    send_rx(8'h77, 16, 1'b0);
    k = 0; peek(3'd5, d);
    while (d[0] !== 1'b1 && k < 100) begin @(negedge clk); k++; peek(3'd5, d); end
    repeat (20) @(negedge clk);
    bus_read(3'd0, d); chk("R10 probe byte", d, 8'h77);

    send_rx(8'h11, 16, 1'b1);
    repeat (10) @(negedge clk);
    send_rx(8'h22, 16, 1'b0);
    repeat (k - 1) @(negedge clk);
    addr = 3'd0; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
    chk("R10 coincident read", d, 8'h11);
    peek(3'd5, d); chk("R10 no overrun", d & 8'h03, 8'h01);
    repeat (20) @(negedge clk);
    bus_read(3'd0, d); chk("R10 new byte stored", d, 8'h22);

    send_rx(8'h33, 16, 1'b1);
    repeat (10) @(negedge clk);
    send_rx(8'h44, 16, 1'b0);
    repeat (k) @(negedge clk);
    addr = 3'd0; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
    chk("R10 late read", d, 8'h33);
    peek(3'd5, d); chk("R10 late read overruns", d & 8'h03, 8'h02);
    repeat (20) @(negedge clk);
    bus_read(3'd5, d);

    // R3 / R5: transmit at divisor 1 and 3
    bus_write(3'd0, 8'hA5);
    peek(3'd5, d); chk("R5 holding busy", d & 8'h60, 8'h00);
    tx_expect(8'hA5, 16, "R3 frame div1");
    repeat (20) @(negedge clk);
    peek(3'd5, d); chk("R5 all empty", d & 8'h60, 8'h60);
    set_div(16'd3);
    bus_write(3'd0, 8'h3C);
    tx_expect(8'h3C, 48, "R3 frame div3");
    set_div(16'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule